// File: doc/BRIEF.md
# Loss-of-Signal Detector and Clock Reference Selector

This block watches the bit stream recovered from a primary-rate line and decides which clock the jitter-attenuating PLL should follow. Once per recovered bit period the receiver marks a bit strobe and tells the block whether that bit crossed the detection threshold. A long enough run of bits below the threshold raises a loss-of-signal flag. While the flag is up, both active-low receive rails are forced to their idle level, so the downstream framer sees no marks.

An external synchronisation clock enters on a single pin. Its frequency is nominally 2.048 MHz for the 2 Mbit/s carrier and 1.544 MHz for the 1.5 Mbit/s carrier. The block resynchronises this pin into the local free-running clock domain. It then counts the pin's rising edges over fixed windows to decide whether a usable clock is present.

A master/slave strap and a fixed priority rule combine the loss flag and the sync activity into a registered two-bit reference code: recovered line clock, sync pin, or free-run with the oscillators centred. A one-cycle strobe comes with every change of the code.

Top module: `los_ref_select`

## Requirements
- R1: `los` rises on the clock edge that takes the 32nd consecutive strobed bit with `mark` low. A strobed bit with `mark` high restarts the run. Cycles without `bit_en` neither add to nor break the run.
- R2: While `los` is 1, `rd_pos_n` and `rd_neg_n` are both 1. While `los` is 0, they follow `rx_pos_n` and `rx_neg_n` combinationally.
- R3: In slave mode (`master_mode`=0) with `los`=0, `ref_sel` is 2'b00, the recovered line clock.
- R4: In slave mode with `los`=1 and the sync pin active, `ref_sel` is 2'b01, the sync pin clock.
- R5: In slave mode with `los`=1 and the sync pin inactive, `ref_sel` is 2'b10, free-run centred.
- R6: In master mode (`master_mode`=1), `los` has no effect on `ref_sel`. The code is 2'b01 while the sync pin is active and 2'b10 otherwise. The code 2'b11 never appears.
- R7: While `los` is 1, strobed bits are grouped into windows of 32, starting with the first strobed bit after `los` rose. `los` falls at the end of a window that held at least 4 marks. A window with 3 or fewer marks leaves `los` set.
- R8: The sync pin is judged over back-to-back windows of 64 local clock cycles. A window with at least 4 rising edges makes it active. A window with no edge makes it inactive. A window with 1 to 3 edges keeps the previous judgement. After reset the pin is inactive.
- R9: `ref_sel` is registered: it reflects the inputs one clock after they settle. `ref_chg` is 1 for exactly one cycle, together with each new value of `ref_sel`. During reset, `ref_sel` is 2'b10, `ref_chg` is 0 and `los` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per recovered bit period |
| mark | input | 1 | Bit crossed the receive threshold (valid with `bit_en`) |
| rx_pos_n | input | 1 | Positive receive rail in, active low |
| rx_neg_n | input | 1 | Negative receive rail in, active low |
| master_mode | input | 1 | 1 = master, 0 = slave |
| sync_in | input | 1 | External sync clock, asynchronous |
| los | output | 1 | Loss-of-signal flag |
| rd_pos_n | output | 1 | Positive receive rail out, active low |
| rd_neg_n | output | 1 | Negative receive rail out, active low |
| ref_sel | output | 2 | 00 line clock, 01 sync pin, 10 free-run centred |
| ref_chg | output | 1 | One-cycle strobe on a change of `ref_sel` |

## Verification
The assertions assume the following about the inputs:
- `master_mode` is a strap that changes only rarely.
- `mark` is read only while `bit_en` is high.
- `sync_in` is a clock much slower than `clk`.

The stimulus keeps to these assumptions. It spaces bit strobes four cycles apart and changes the mode only between directed phases. It drives the sync pin as a square wave whose half period is at least three local cycles. The random phase draws the mark density and the rail levels from a fixed seed, so the run is repeatable.

// File: rtl/los_ref_select.sv
`timescale 1ns/1ps
module los_ref_select #(
  parameter int LOS_BITS   = 32,
  parameter int CLR_WIN    = 32,
  parameter int CLR_MARKS  = 4,
  parameter int SYNC_WIN   = 64,
  parameter int SYNC_EDGES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       mark,
  input  logic       rx_pos_n,
  input  logic       rx_neg_n,
  input  logic       master_mode,
  input  logic       sync_in,
  output logic       los,
  output logic       rd_pos_n,
  output logic       rd_neg_n,
  output logic [1:0] ref_sel,
  output logic       ref_chg
);
  localparam int ZW = $clog2(LOS_BITS + 1);
  localparam int WW = $clog2(CLR_WIN + 1);
  localparam int MW = $clog2(CLR_MARKS + 1);
  localparam int SW = $clog2(SYNC_WIN);
  localparam int EW = $clog2(SYNC_EDGES + 1);
  localparam logic [1:0] SEL_LINE = 2'b00;
  localparam logic [1:0] SEL_SYNC = 2'b01;
  localparam logic [1:0] SEL_FREE = 2'b10;

  logic [ZW-1:0] zero_cnt;
  logic [WW-1:0] win_cnt;
  logic [MW-1:0] mark_cnt, marks_nxt;

  assign marks_nxt = (mark && mark_cnt != MW'(CLR_MARKS)) ? mark_cnt + 1'b1 : mark_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      los      <= 1'b0;
      zero_cnt <= '0;
      win_cnt  <= '0;
      mark_cnt <= '0;
    end else if (bit_en) begin
      if (!los) begin
        win_cnt  <= '0;
        mark_cnt <= '0;
        if (mark) zero_cnt <= '0;
        else if (zero_cnt == ZW'(LOS_BITS - 1)) begin
          zero_cnt <= '0;
          los      <= 1'b1;
        end else zero_cnt <= zero_cnt + 1'b1;
      end else begin
        zero_cnt <= '0;
        if (win_cnt == WW'(CLR_WIN - 1)) begin
          win_cnt  <= '0;
          mark_cnt <= '0;
          if (marks_nxt == MW'(CLR_MARKS)) los <= 1'b0;
        end else begin
          win_cnt  <= win_cnt + 1'b1;
          mark_cnt <= marks_nxt;
        end
      end
    end
  end

  assign rd_pos_n = los | rx_pos_n;
  assign rd_neg_n = los | rx_neg_n;

  logic [2:0]    sync_sh;
  logic          sync_rise, sync_act;
  logic [SW-1:0] sync_tick;
  logic [EW-1:0] edge_cnt, edges_nxt;

  assign sync_rise = sync_sh[1] & ~sync_sh[2];
  assign edges_nxt = (sync_rise && edge_cnt != EW'(SYNC_EDGES)) ? edge_cnt + 1'b1 : edge_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_sh   <= '0;
      sync_tick <= '0;
      edge_cnt  <= '0;
      sync_act  <= 1'b0;
    end else begin
      sync_sh   <= {sync_sh[1:0], sync_in};
      sync_tick <= sync_tick + 1'b1;
      if (sync_tick == SW'(SYNC_WIN - 1)) begin
        edge_cnt <= '0;
        if (edges_nxt == EW'(SYNC_EDGES)) sync_act <= 1'b1;
        else if (edges_nxt == '0)         sync_act <= 1'b0;
      end else edge_cnt <= edges_nxt;
    end
  end

  logic [1:0] sel_nxt;
  always_comb begin
    if (!master_mode && !los) sel_nxt = SEL_LINE;
    else if (sync_act)        sel_nxt = SEL_SYNC;
    else                      sel_nxt = SEL_FREE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_sel <= SEL_FREE;
      ref_chg <= 1'b0;
    end else begin
      ref_sel <= sel_nxt;
      ref_chg <= (sel_nxt != ref_sel);
    end
  end

  AST_LOS_ONLY_ON_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> ($past(bit_en) && !$past(mark))); // R1
  AST_LOS_CLEAR_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> ($past(bit_en) && $past(rst_n))); // R7
  AST_SLAVE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(master_mode) && !$past(los)) |-> ref_sel == SEL_LINE); // R3
  AST_SLAVE_LOS_NOT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(los)) |-> ref_sel != SEL_LINE); // R4
  AST_MASTER_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(master_mode)) |-> ref_sel != SEL_LINE); // R6
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ref_sel != 2'b11); // R6
  AST_SYNC_ACT_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $changed(sync_act)) |-> sync_tick == '0); // R8
  AST_CHG_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ref_chg) |-> ref_sel != $past(ref_sel)); // R9
  AST_CHANGE_MEANS_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ref_sel != $past(ref_sel)) |-> ref_chg); // R9
endmodule

// File: tb/test_los_ref_select.sv
`timescale 1ns/1ps
module test_los_ref_select;
  logic clk = 0, rst_n = 0, bit_en = 0, mark = 0;
  logic rx_pos_n = 1, rx_neg_n = 1, master_mode = 0, sync_in = 0;
  logic los, rd_pos_n, rd_neg_n, ref_chg;
  logic [1:0] ref_sel;

  los_ref_select i_los_ref_select (.*);

  always #4 clk = ~clk;

  int checks = 0, failures = 0, chg_cnt = 0;
  int sync_half = 0, sync_ctr = 0;
  bit m_los = 0, sync_exp = 0;
  int m_zc = 0, m_wc = 0, m_mc = 0;

  always @(negedge clk) chg_cnt += (rst_n && ref_chg) ? 1 : 0;

  always @(negedge clk) begin
    if (sync_half == 0) begin sync_in <= 0; sync_ctr <= 0; end
    else if (sync_ctr >= sync_half - 1) begin sync_in <= ~sync_in; sync_ctr <= 0; end
    else sync_ctr <= sync_ctr + 1;
  end

  function automatic logic [1:0] exp_sel(bit mst, bit l, bit s);
    if (!mst && !l) return 2'b00;
    if (s) return 2'b01;
    return 2'b10;
  endfunction

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_bit(bit m);
    if (!m_los) begin
      m_wc = 0; m_mc = 0;
      if (m) m_zc = 0;
      else begin m_zc++; if (m_zc == 32) begin m_los = 1; m_zc = 0; end end
    end else begin
      m_wc++; if (m) m_mc++;
      if (m_wc == 32) begin
        if (m_mc >= 4) m_los = 0;
        m_wc = 0; m_mc = 0;
      end
    end
  endtask

  task automatic send_bit(bit m, bit p, bit n);
    @(negedge clk);
    bit_en = 1; mark = m; rx_pos_n = p; rx_neg_n = n;
    @(negedge clk);
    bit_en = 0; mark = ~m;
    model_bit(m);
    chk(los, m_los, "R1/R7 los");
    chk(rd_pos_n, m_los ? 1 : p, "R2 rd_pos_n");
    chk(rd_neg_n, m_los ? 1 : n, "R2 rd_neg_n");
    @(negedge clk);
    @(negedge clk);
    chk(ref_sel, exp_sel(master_mode, m_los, sync_exp), "R3/R4/R5/R6 ref_sel");
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c0;
    void'($urandom(1234));
    wait_cyc(5);
    chk(los, 0, "R9 reset los");
    chk(ref_sel, 2'b10, "R9 reset ref_sel");
    chk(ref_chg, 0, "R9 reset ref_chg");
    rst_n = 1;
    wait_cyc(3);
    chk(ref_sel, 2'b00, "R3 slave after reset");
    chk(chg_cnt, 1, "R9 one strobe after reset");

    for (int i = 0; i < 200; i++) send_bit($urandom_range(1, 0), $urandom_range(1, 0), $urandom_range(1, 0));
    for (int i = 0; i < 400; i++) send_bit($urandom_range(15, 0) == 0, $urandom_range(1, 0), $urandom_range(1, 0));

    while (m_los) send_bit(1, 1, 1);
    send_bit(1, 1, 1);
    for (int i = 0; i < 31; i++) send_bit(0, 1, 1);
    chk(los, 0, "R1 no los after 31 spaces");
    c0 = chg_cnt;
    send_bit(0, 0, 0);
    chk(los, 1, "R1 los on 32nd space");
    chk(ref_sel, 2'b10, "R5 slave los no sync");
    chk(chg_cnt - c0, 1, "R9 single strobe");

    sync_half = 3; wait_cyc(300); sync_exp = 1;
    chk(ref_sel, 2'b01, "R4 slave los sync active");
    send_bit(0, 0, 0);
    chk(rd_pos_n, 1, "R2 rail idle in los");

    for (int i = 0; i < 32; i++) send_bit(i < 3, 0, 0);
    chk(los, 1, "R7 three marks keep los");
    for (int i = 0; i < 32; i++) send_bit(i % 8 == 0, 0, 1);
    chk(los, 0, "R7 four marks clear los");
    chk(ref_sel, 2'b00, "R3 line after clear");

    sync_half = 0; wait_cyc(300); sync_exp = 0;
    master_mode = 1; wait_cyc(3);
    chk(ref_sel, 2'b10, "R6 master free run");
    sync_half = 40; wait_cyc(600);
    chk(ref_sel, 2'b10, "R8 sparse edges stay inactive");
    sync_half = 3; wait_cyc(300); sync_exp = 1;
    chk(ref_sel, 2'b01, "R6 master sync");
    sync_half = 16; wait_cyc(600);
    chk(ref_sel, 2'b01, "R8 two edges per window hold active");
    c0 = chg_cnt;
    for (int i = 0; i < 32; i++) send_bit(0, 1, 1);
    chk(los, 1, "R1 los in master");
    chk(ref_sel, 2'b01, "R6 master ignores los");
    chk(chg_cnt - c0, 0, "R6 no strobe from los in master");
    sync_half = 0; wait_cyc(300); sync_exp = 0;
    chk(ref_sel, 2'b10, "R8 silent window inactive");
    master_mode = 0; wait_cyc(3);
    chk(ref_sel, 2'b10, "R5 slave los no sync");
    for (int i = 0; i < 32; i++) send_bit(1, 1, 0);
    chk(ref_sel, 2'b00, "R3 line restored");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule